// File: doc/BRIEF.md
# FP64 Round-to-Integral Unit

This unit takes one IEEE-754 double-precision operand and rounds it to an integral value, still in double format. A 2-bit dynamic mode input picks one of four rounding directions. The result leaves the unit one clock after the operand is presented. It sits in the low doubleword of a 128-bit destination word whose high doubleword is forced to zero. Operands can be accepted every cycle.

Along with the value, the unit reports several status bits: a signaling-NaN invalid flag, an inexact flag, a "magnitude was incremented" flag, a "fraction inexact" flag and a 5-bit class code of the result. An invalid-trap enable that arrives with the operand lets an invalid signaling-NaN operation cancel the writeback. In that case the write strobe and the class-update strobe stay low, and the increment and fraction-inexact flags are cleared. Register-file access and exception delivery belong to the surrounding pipeline. That pipeline uses the write and update strobes this unit exposes.

Top module: `fp64_rint_unit`

## Requirements
- R1: An operand presented with `in_valid` high produces `out_valid` high on the next clock, and the result and flags for that operand appear in the same cycle. A cycle with `in_valid` low produces `out_valid`, `out_wr_en`, `out_class_upd` and every flag low one cycle later.
- R2: The rounded double is placed in `out_result[63:0]`, and `out_result[127:64]` is all zeros.
- R3: Mode code 00 rounds to the nearest integer. An exact tie between two integers goes to the even one, so 2.5 gives 2.0 and 3.5 gives 4.0. A carry out of the significand raises the exponent, so 1.75 gives 2.0.
- R4: Mode code 01 rounds toward zero, mode code 10 rounds toward +infinity and mode code 11 rounds toward -infinity.
- R5: A signaling NaN (exponent all ones, fraction nonzero, fraction bit 51 clear) sets `out_snan` and is returned with fraction bit 51 set. A quiet NaN, an infinity or a signed zero passes through unchanged, with `out_snan` low.
- R6: `out_inexact` is high exactly when the rounded value differs from a finite operand. An operand whose biased exponent is 1075 or more is returned bit-for-bit with `out_inexact` low.
- R7: When `in_inv_trap_en` was high and the operand was a signaling NaN, `out_wr_en`, `out_class_upd`, `out_frac_rnd` and `out_frac_inx` are all low, while `out_snan` is still high.
- R8: In every other valid cycle, `out_wr_en` is high, `out_frac_rnd` equals "the magnitude of the result exceeds that of the operand", and `out_frac_inx` equals `out_inexact`.
- R9: When the result is written, `out_class` gives the result class: quiet NaN 10001, -infinity 01001, -normal 01000, -zero 10010, +zero 00010, +normal 00100, +infinity 00101, -denormal 11000 and +denormal 10100. `out_class_upd` equals `out_wr_en`, and `out_class` is 00000 when no write occurs.
- R10: A nonzero operand of magnitude below 1 (including denormals) rounds to a zero or a one that keeps the operand's sign. Under mode 00, exactly 0.5 rounds to zero and anything above 0.5 rounds to one.
- R11: While reset is asserted, and until the first operand after reset, `out_valid`, `out_wr_en`, `out_class_upd` and all flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the unit |
| in_valid | input | 1 | Operand present this cycle |
| in_op | input | 64 | Double-precision operand |
| in_rmode | input | 2 | Rounding mode: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| in_inv_trap_en | input | 1 | Invalid-operation trap enable for this operand |
| out_valid | output | 1 | Result cycle for the previous operand |
| out_result | output | 128 | Rounded double in the low 64 bits, zeros above |
| out_wr_en | output | 1 | Destination write strobe |
| out_class_upd | output | 1 | Class-code update strobe |
| out_class | output | 5 | Result class code |
| out_snan | output | 1 | Invalid operation: signaling-NaN operand |
| out_inexact | output | 1 | Result differs from operand |
| out_frac_rnd | output | 1 | Magnitude was incremented (cleared on suppressed write) |
| out_frac_inx | output | 1 | Fraction inexact (cleared on suppressed write) |

## Verification
The unit holds state for only one cycle, so a wrong internal value shows up at the ports in the very next result cycle, with no masking from later operands. A bad rounding increment or mask shows up as a result one unit in the last integer place away from the expected one. It also disagrees with `out_frac_rnd` or `out_inexact` in that same cycle. A wrong captured trap enable or NaN decode flips `out_wr_en` and the cleared flags together. The bench therefore compares every output field against a real-arithmetic model on every clock. It covers ties, carries, denormals, large exponents and special values in all four modes.

// File: rtl/fp64_rint_pkg.sv
package fp64_rint_pkg;
  localparam int unsigned EXP_W  = 11;
  localparam int unsigned FRAC_W = 52;
  localparam int unsigned CLS_W  = 5;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_TO_ZERO = 2'b01,
    RM_UP      = 2'b10,
    RM_DOWN    = 2'b11
  } rmode_e;

  localparam logic [CLS_W-1:0] CLS_QNAN    = 5'b10001;
  localparam logic [CLS_W-1:0] CLS_NEG_INF = 5'b01001;
  localparam logic [CLS_W-1:0] CLS_NEG_NRM = 5'b01000;
  localparam logic [CLS_W-1:0] CLS_NEG_DEN = 5'b11000;
  localparam logic [CLS_W-1:0] CLS_NEG_ZER = 5'b10010;
  localparam logic [CLS_W-1:0] CLS_POS_ZER = 5'b00010;
  localparam logic [CLS_W-1:0] CLS_POS_DEN = 5'b10100;
  localparam logic [CLS_W-1:0] CLS_POS_NRM = 5'b00100;
  localparam logic [CLS_W-1:0] CLS_POS_INF = 5'b00101;
endpackage

// File: rtl/fp64_rint_core.sv
module fp64_rint_core
  import fp64_rint_pkg::*;
#(
  parameter int unsigned EW = EXP_W,
  parameter int unsigned FW = FRAC_W
) (
  input  logic [EW+FW:0] op_i,
  input  logic [1:0]     mode_i,
  output logic [EW+FW:0] res_o,
  output logic           snan_o,
  output logic           inexact_o,
  output logic           incr_o
);
  localparam int unsigned M = FW + 1;
  localparam logic [EW:0]   BIAS     = {2'b00, {(EW-1){1'b1}}};
  localparam logic [EW:0]   INT_EXP  = BIAS + (EW+1)'(FW);
  localparam logic [EW-1:0] ONE_EXP  = BIAS[EW-1:0];
  localparam logic [EW-1:0] HALF_EXP = BIAS[EW-1:0] - 1'b1;

  logic          sgn;
  logic [EW-1:0] ex;
  logic [FW-1:0] fr;
  logic [EW:0]   ex_x, sh_x;
  logic [M:0]    one_sh;
  logic [M-1:0]  unit, mask, half, man, low, trunc;
  logic [M:0]    sum;
  logic          fr_nz, lo_nz, odd, up_mid, up_small;
  rmode_e        mode;

  assign sgn   = op_i[EW+FW];
  assign ex    = op_i[EW+FW-1:FW];
  assign fr    = op_i[FW-1:0];
  assign ex_x  = {1'b0, ex};
  assign fr_nz = |fr;
  assign mode  = rmode_e'(mode_i);

  // Position of the integer LSB: the number of fraction bits below the point.
  assign sh_x   = INT_EXP - ex_x;
  assign one_sh = {{M{1'b0}}, 1'b1} << sh_x;
  assign unit   = one_sh[M-1:0];
  assign half   = one_sh[M:1];
  assign mask   = unit - 1'b1;
  assign man    = {1'b1, fr};
  assign low    = man & mask;
  assign trunc  = man & ~mask;
  assign lo_nz  = |low;
  assign odd    = |(trunc & unit);

  always_comb begin
    unique case (mode)
      RM_NEAREST: up_mid = (low > half) || ((low == half) && odd);
      RM_TO_ZERO: up_mid = 1'b0;
      RM_UP:      up_mid = lo_nz & ~sgn;
      default:    up_mid = lo_nz & sgn;
    endcase
  end

  // Magnitude below one: result is zero or one.
  always_comb begin
    unique case (mode)
      RM_NEAREST: up_small = (ex == HALF_EXP) && fr_nz;
      RM_TO_ZERO: up_small = 1'b0;
      RM_UP:      up_small = ~sgn;
      default:    up_small = sgn;
    endcase
  end

  assign sum = {1'b0, trunc} + (up_mid ? {1'b0, unit} : '0);

  always_comb begin
    res_o     = op_i;
    snan_o    = 1'b0;
    inexact_o = 1'b0;
    incr_o    = 1'b0;
    if (&ex) begin
      if (fr_nz) begin
        res_o[FW-1] = 1'b1;
        snan_o      = ~fr[FW-1];
      end
    end else if ((ex_x >= INT_EXP) || ((ex == '0) && !fr_nz)) begin
      res_o = op_i;
    end else if (ex_x < BIAS) begin
      inexact_o = 1'b1;
      incr_o    = up_small;
      res_o     = {sgn, (up_small ? ONE_EXP : {EW{1'b0}}), {FW{1'b0}}};
    end else begin
      inexact_o = lo_nz;
      incr_o    = up_mid;
      if (sum[M]) res_o = {sgn, ex + 1'b1, {FW{1'b0}}};
      else        res_o = {sgn, ex, sum[FW-1:0]};
    end
  end
endmodule

// File: rtl/fp64_rint_class.sv
module fp64_rint_class
  import fp64_rint_pkg::*;
#(
  parameter int unsigned EW = EXP_W,
  parameter int unsigned FW = FRAC_W
) (
  input  logic [EW+FW:0]    val_i,
  output logic [CLS_W-1:0]  cls_o
);
  logic          sgn;
  logic [EW-1:0] ex;
  logic          fr_nz;

  assign sgn   = val_i[EW+FW];
  assign ex    = val_i[EW+FW-1:FW];
  assign fr_nz = |val_i[FW-1:0];

  always_comb begin
    if (&ex)             cls_o = fr_nz ? CLS_QNAN : (sgn ? CLS_NEG_INF : CLS_POS_INF);
    else if (ex == '0)   cls_o = fr_nz ? (sgn ? CLS_NEG_DEN : CLS_POS_DEN)
                                       : (sgn ? CLS_NEG_ZER : CLS_POS_ZER);
    else                 cls_o = sgn ? CLS_NEG_NRM : CLS_POS_NRM;
  end
endmodule

// File: rtl/fp64_rint_unit.sv
module fp64_rint_unit
  import fp64_rint_pkg::*;
#(
  parameter int unsigned EW      = EXP_W,
  parameter int unsigned FW      = FRAC_W,
  parameter int unsigned SYNC_ST = 2,
  localparam int unsigned DW     = EW + FW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DW-1:0]     in_op,
  input  logic [1:0]        in_rmode,
  input  logic              in_inv_trap_en,
  output logic              out_valid,
  output logic [2*DW-1:0]   out_result,
  output logic              out_wr_en,
  output logic              out_class_upd,
  output logic [CLS_W-1:0]  out_class,
  output logic              out_snan,
  output logic              out_inexact,
  output logic              out_frac_rnd,
  output logic              out_frac_inx
);
  localparam logic [EW:0] INT_EXP = {2'b00, {(EW-1){1'b1}}} + (EW+1)'(FW);

  // Reset: asserted asynchronously, released through a synchronizer.
  logic [SYNC_ST-1:0] rs_q;
  logic               rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[SYNC_ST-2:0], 1'b1};
  end
  assign rst_q_n = rs_q[SYNC_ST-1];

  logic [DW-1:0] core_res;
  logic          core_snan, core_inx, core_inc;

  fp64_rint_core #(.EW(EW), .FW(FW)) u_core (
    .op_i      (in_op),
    .mode_i    (in_rmode),
    .res_o     (core_res),
    .snan_o    (core_snan),
    .inexact_o (core_inx),
    .incr_o    (core_inc)
  );

  // Next-state
  logic          vld_d, vld_q;
  logic [DW-1:0] res_d, res_q;
  logic          snan_d, snan_q, inx_d, inx_q, inc_d, inc_q, trap_d, trap_q;
  logic          cap_en;

  assign cap_en = in_valid;
  always_comb begin
    vld_d  = in_valid;
    res_d  = res_q;
    snan_d = snan_q;
    inx_d  = inx_q;
    inc_d  = inc_q;
    trap_d = trap_q;
    if (cap_en) begin
      res_d  = core_res;
      snan_d = core_snan;
      inx_d  = core_inx;
      inc_d  = core_inc;
      trap_d = in_inv_trap_en;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      vld_q  <= 1'b0;
      res_q  <= '0;
      snan_q <= 1'b0;
      inx_q  <= 1'b0;
      inc_q  <= 1'b0;
      trap_q <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      res_q  <= res_d;
      snan_q <= snan_d;
      inx_q  <= inx_d;
      inc_q  <= inc_d;
      trap_q <= trap_d;
    end
  end

  logic [CLS_W-1:0] cls;
  fp64_rint_class #(.EW(EW), .FW(FW)) u_class (
    .val_i (res_q),
    .cls_o (cls)
  );

  logic wr;
  assign wr            = vld_q & ~(trap_q & snan_q);
  assign out_valid     = vld_q;
  assign out_result    = {{DW{1'b0}}, res_q};
  assign out_wr_en     = wr;
  assign out_class_upd = wr;
  assign out_class     = wr ? cls : '0;
  assign out_snan      = vld_q & snan_q;
  assign out_inexact   = vld_q & inx_q;
  assign out_frac_rnd  = wr & inc_q;
  assign out_frac_inx  = wr & inx_q;

  // Assertions
  logic in_is_snan;
  assign in_is_snan = (&in_op[DW-2:FW]) && (|in_op[FW-1:0]) && !in_op[FW-1];

  p_valid_next_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> out_valid);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> (!out_valid && !out_wr_en && !out_snan && !out_inexact));
  p_snan_quiet_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && in_is_snan) |=> (out_snan && out_result[FW-1]));
  p_big_exact_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && ({1'b0, in_op[DW-2:FW]} >= INT_EXP) && !(&in_op[DW-2:FW]))
    |=> (out_result[DW-1:0] == $past(in_op) && !out_inexact));
  p_trap_cancel_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && in_inv_trap_en && in_is_snan)
    |=> (!out_wr_en && !out_class_upd && !out_frac_rnd && !out_frac_inx));
  p_incr_inexact_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_frac_rnd |-> out_frac_inx);
  p_class_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_class_upd |-> (out_class != '0));
endmodule

// File: tb/test_fp64_rint_unit.sv
`timescale 1ns/1ps
module test_fp64_rint_unit;
  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [63:0]  in_op;
  logic [1:0]   in_rmode;
  logic         in_inv_trap_en;
  logic         out_valid;
  logic [127:0] out_result;
  logic         out_wr_en;
  logic         out_class_upd;
  logic [4:0]   out_class;
  logic         out_snan;
  logic         out_inexact;
  logic         out_frac_rnd;
  logic         out_frac_inx;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  fp64_rint_unit i_fp64_rint_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_rmode(in_rmode), .in_inv_trap_en(in_inv_trap_en),
    .out_valid(out_valid), .out_result(out_result), .out_wr_en(out_wr_en),
    .out_class_upd(out_class_upd), .out_class(out_class), .out_snan(out_snan),
    .out_inexact(out_inexact), .out_frac_rnd(out_frac_rnd),
    .out_frac_inx(out_frac_inx)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference using real arithmetic.
  function automatic logic [63:0] ref_round(input logic [63:0] x, input logic [1:0] m,
                                            output bit xx, output bit inc, output bit sn);
    real r, f, c, res, ar, ares;
    logic [63:0] rb;
    xx = 0; inc = 0; sn = 0;
    if (x[62:52] == 11'h7FF) begin
      sn = (x[51:0] != 0) && !x[51];
      return (x[51:0] != 0) ? (x | (64'd1 << 51)) : x;
    end
    if (x[62:52] >= 11'd1075 || x[62:0] == 0) return x;
    r = $bitstoreal(x);
    f = $floor(r);
    c = $ceil(r);
    case (m)
      2'b00: begin
        if (r - f > 0.5)      res = c;
        else if (r - f < 0.5) res = f;
        else                  res = ($floor(f / 2.0) * 2.0 == f) ? f : c;
      end
      2'b01: res = (r < 0.0) ? c : f;
      2'b10: res = c;
      default: res = f;
    endcase
    rb = $realtobits(res);
    rb[63] = x[63];
    ar   = (r < 0.0) ? -r : r;
    ares = (res < 0.0) ? -res : res;
    xx  = (res != r);
    inc = (ares > ar);
    return rb;
  endfunction

  function automatic logic [4:0] ref_class(input logic [63:0] v);
    if (v[62:52] == 11'h7FF) return (v[51:0] != 0) ? 5'b10001 : (v[63] ? 5'b01001 : 5'b00101);
    if (v[62:52] == 0) begin
      if (v[51:0] == 0) return v[63] ? 5'b10010 : 5'b00010;
      return v[63] ? 5'b11000 : 5'b10100;
    end
    return v[63] ? 5'b01000 : 5'b00100;
  endfunction

  // Drive one cycle, then compare the registered outputs on the following negedge.
  task automatic step(input bit v, input logic [63:0] x, input logic [1:0] m, input bit t);
    logic [63:0] e;
    bit sx, si, ss, wr;
    string tag;
    in_valid = v; in_op = x; in_rmode = m; in_inv_trap_en = t;
    e = ref_round(x, m, sx, si, ss);
    if (x[62:52] == 11'h7FF)                       tag = "R5 result";
    else if (x[62:52] < 11'd1023 && x[62:0] != 0)  tag = "R10 result";
    else if (m != 2'b00)                           tag = "R4 result";
    else                                           tag = "R3 result";
    @(negedge clk);
    wr = v && !(t && ss);
    chk(out_valid == v, "R1 out_valid", 128'(out_valid), 128'(v));
    if (v) begin
      chk(out_result[63:0] == e, tag, out_result, {64'd0, e});
      chk(out_result[127:64] == 0, "R2 upper zero", out_result, {64'd0, e});
    end
    chk(out_snan == (v && ss), "R5 snan flag", 128'(out_snan), 128'(v && ss));
    chk(out_inexact == (v && sx), "R6 inexact", 128'(out_inexact), 128'(v && sx));
    chk(out_wr_en == wr, (t && ss) ? "R7 wr_en" : "R8 wr_en", 128'(out_wr_en), 128'(wr));
    chk(out_frac_rnd == (wr && si), (t && ss) ? "R7 frac_rnd" : "R8 frac_rnd",
        128'(out_frac_rnd), 128'(wr && si));
    chk(out_frac_inx == (wr && sx), (t && ss) ? "R7 frac_inx" : "R8 frac_inx",
        128'(out_frac_inx), 128'(wr && sx));
    chk(out_class_upd == wr, "R9 class_upd", 128'(out_class_upd), 128'(wr));
    chk(out_class == (wr ? ref_class(e) : 5'd0), "R9 class",
        128'(out_class), 128'(wr ? ref_class(e) : 5'd0));
  endtask

  task automatic all_modes(input logic [63:0] x, input bit t);
    for (int m = 0; m < 4; m++) step(1'b1, x, 2'(m), t);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 0; in_op = '0; in_rmode = '0; in_inv_trap_en = 0;
    // R11: quiet outputs during reset.
    repeat (3) begin
      @(negedge clk);
      chk(!out_valid && !out_wr_en && !out_class_upd && !out_snan && !out_inexact
          && !out_frac_rnd && !out_frac_inx, "R11 reset state",
          {out_valid, out_wr_en, out_class_upd, out_snan, out_inexact, out_frac_rnd,
           out_frac_inx}, 128'd0);
    end
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(!out_valid && !out_wr_en, "R11 after release", 128'(out_valid), 128'd0);
    end

    // R3 ties, carry; R4 directed; R10 small magnitudes
    all_modes($realtobits(0.5), 0);
    all_modes($realtobits(-0.5), 0);
    all_modes($realtobits(1.5), 0);
    all_modes($realtobits(2.5), 0);
    all_modes($realtobits(-2.5), 0);
    all_modes($realtobits(3.5), 0);
    all_modes($realtobits(1.75), 0);
    all_modes($realtobits(0.3), 0);
    all_modes($realtobits(-0.3), 0);
    all_modes($realtobits(0.7), 0);
    all_modes($realtobits(-0.7), 0);
    all_modes($realtobits(1.0), 0);
    all_modes($realtobits(-7.0), 0);
    all_modes($realtobits(4503599627370495.5), 0);
    all_modes($realtobits(-4503599627370495.5), 0);
    all_modes(64'h0000_0000_0000_0001, 0);   // R10 +denormal
    all_modes(64'h8000_0000_0000_0001, 0);   // R10 -denormal
    // R6 already-integral large exponents
    all_modes(64'h4330_0000_0000_0001, 0);
    all_modes(64'hC7EF_FFFF_FFFF_FFFF, 0);
    // R5 specials, R7 trap suppression
    all_modes(64'h0000_0000_0000_0000, 0);
    all_modes(64'h8000_0000_0000_0000, 0);
    all_modes(64'h7FF0_0000_0000_0000, 0);
    all_modes(64'hFFF0_0000_0000_0000, 1);
    all_modes(64'h7FF8_0000_0000_1234, 1);
    all_modes(64'h7FF0_0000_0000_0001, 0);
    all_modes(64'hFFF4_0000_0000_0000, 1);
    // R1 idle gap between operands
    step(1'b0, 64'h3FF8_0000_0000_0000, 2'b00, 0);
    step(1'b1, $realtobits(-1.25), 2'b10, 0);
    step(1'b0, 64'hFFF4_0000_0000_0000, 2'b00, 1);

    for (int i = 0; i < 3000; i++) begin
      logic [63:0] x;
      x = {$urandom, $urandom};
      if (i % 8 != 0) x[62:52] = 11'(1000 + ($urandom % 90));
      if (i % 50 == 0) x[62:51] = 12'hFFE;     // signaling NaN
      step(($urandom % 10) != 0, x, 2'($urandom), 1'($urandom));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired R1 actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end
endmodule